// File: doc/BRIEF.md
# Dual-Channel Converter Sample Distributor

This block sits between a sample stream and a pair of 8-bit converter code registers. A free-running rate divider sets the conversion tick. On each tick the block offers to take one sample from a valid/ready stream. The accepted sample has a signed offset added to it, with the sum clamped to the code range. The result then goes to the output channels. A two-bit mask enables the channels. A fan-out mode either copies each sample to every enabled channel or deals samples to the two channels in turn.

Each code output holds its value between writes, so a stream that runs dry leaves the last level on the pins. Starting a run clears both codes to zero, and they stay there until the first sample lands. Two one-clock event pulses report progress. The first marks the completion of each programmed group of samples. The second marks the first tick that finds no sample after data had been flowing.

Top module: `dac_stream_fanout`

## Requirements
- R1: While and after reset, `code0` and `code1` are 0 and `s_ready`, `blk_done` and `starved` are low.
- R2: While `enable` is high, `s_ready` is high in exactly one cycle out of every `div_val`+1. While `enable` is low, `s_ready` stays low. A sample is accepted in a cycle where `s_valid` and `s_ready` are both high.
- R3: The value written is `s_data` (unsigned) plus `offset` (two's complement, -128..127), clamped to 0..255.
- R4: With `alt_mode`=0, each accepted sample is written, in the cycle after acceptance, to every channel whose mask bit is set. Bit 0 of `chan_mask` enables `code0` and bit 1 enables `code1`.
- R5: With `alt_mode`=1 and `chan_mask`=2'b11, the first sample accepted after a start goes to `code0`, the next to `code1`, and so on alternately.
- R6: With `alt_mode`=1 and only one mask bit set, every accepted sample goes to that one channel.
- R7: A code changes only when a sample is written to its channel or at a start. Without accepted samples, both codes hold.
- R8: A start is the first cycle with `enable` high after a cycle with it low. A start clears both codes to 0 at the end of that cycle, unless a sample is written to the channel in that same cycle.
- R9: `blk_done` pulses high for one cycle after the accept that completes each group of `block_len` samples. A `block_len` of 0 behaves as 1. The group count restarts at each start.
- R10: `starved` pulses high for one cycle after the first tick that finds `s_valid` low, provided at least one sample has been accepted since the last start or the last such tick.
- R11: With `chan_mask`=2'b00, samples are still accepted on ticks, but neither code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; a rising level is a start |
| div_val | input | 16 | Tick period minus one, in clocks |
| chan_mask | input | 2 | Channel enables, bit 0 = code0, bit 1 = code1 |
| alt_mode | input | 1 | 0 = copy to all enabled channels, 1 = alternate |
| offset | input | 8 | Signed offset added to each sample |
| block_len | input | 16 | Samples per group for the group event |
| s_valid | input | 1 | Sample stream valid |
| s_data | input | 8 | Sample stream data |
| s_ready | output | 1 | High on a conversion tick |
| code0 | output | 8 | Converter code, channel 0 |
| code1 | output | 8 | Converter code, channel 1 |
| blk_done | output | 1 | One-cycle pulse at each completed group |
| starved | output | 1 | One-cycle pulse when the stream runs dry |

## Verification
A wrong turn bit in the alternation logic shows up one cycle after the next accept, as a sample landing on the wrong code pin. A wrong group count or a stale "data seen" flag shows as a `blk_done` or `starved` pulse that is missing or misplaced, no later than the end of the current group or the next dry tick. A corrupted divider count shifts the spacing of `s_ready`, which is visible within one tick period. The offset clamp is checked against every 8-bit sample value at offsets that include both range ends.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int unsigned DSF_NCH = 2;
    localparam int unsigned DSF_DW  = 8;

    typedef logic [DSF_DW-1:0] code_t;

    typedef enum logic {
        FAN_SIMUL = 1'b0,
        FAN_ALTER = 1'b1
    } fan_mode_t;

    typedef struct packed {
        logic  wr;
        code_t val;
    } lane_cmd_t;

    // Unsigned sample plus signed offset, clamped to the code range.
    function automatic code_t sat_add(input code_t smp, input code_t off);
        logic signed [DSF_DW+1:0] sum;
        logic signed [DSF_DW+1:0] top;
        sum = $signed({2'b00, smp}) + $signed({{2{off[DSF_DW-1]}}, off});
        top = $signed({2'b00, {DSF_DW{1'b1}}});
        if (sum < 0)
            return '0;
        else if (sum > top)
            return {DSF_DW{1'b1}};
        else
            return code_t'(sum[DSF_DW-1:0]);
    endfunction

endpackage

// File: rtl/dsf_tick_gen.sv
module dsf_tick_gen #(
    parameter int unsigned DIVW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt >= div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt >= div);
endmodule

// File: rtl/dsf_fanout.sv
module dsf_fanout
    import dsf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       accept,
    input  fan_mode_t                  mode,
    input  logic [DSF_NCH-1:0]         mask,
    input  code_t                      val,
    output lane_cmd_t [DSF_NCH-1:0]    cmd
);
    logic turn;
    logic dealing;

    assign dealing = (mode == FAN_ALTER) && (&mask);

    always_ff @(posedge clk) begin
        if (rst || !en)
            turn <= 1'b0;
        else if (accept && dealing)
            turn <= ~turn;
    end

    for (genvar c = 0; c < DSF_NCH; c++) begin : g_route
        logic mine;
        assign mine       = !dealing || (32'(turn) == c);
        assign cmd[c].wr  = accept && mask[c] && mine;
        assign cmd[c].val = val;
    end
endmodule

// File: rtl/dsf_lane.sv
module dsf_lane
    import dsf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  lane_cmd_t cmd,
    output code_t     code
);
    always_ff @(posedge clk) begin
        if (rst)
            code <= '0;
        else if (cmd.wr)
            code <= cmd.val;
        else if (start)
            code <= '0;
    end
endmodule

// File: rtl/dsf_event_gen.sv
module dsf_event_gen #(
    parameter int unsigned LENW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic            s_valid,
    input  logic            accept,
    input  logic [LENW-1:0] blk_len,
    output logic            blk_done,
    output logic            starved
);
    logic [LENW-1:0] cnt;
    logic            had;
    logic [LENW:0]   nxt;
    logic            last;

    assign nxt  = {1'b0, cnt} + (LENW+1)'(1);
    assign last = nxt >= {1'b0, blk_len};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt      <= '0;
            had      <= 1'b0;
            blk_done <= 1'b0;
            starved  <= 1'b0;
        end else begin
            blk_done <= accept && last;
            if (accept)
                cnt <= last ? '0 : nxt[LENW-1:0];
            starved <= tick && !s_valid && had;
            if (tick)
                had <= s_valid;
        end
    end
endmodule

// File: rtl/dac_stream_fanout.sv
module dac_stream_fanout
    import dsf_pkg::*;
#(
    parameter int unsigned DIVW = 16,
    parameter int unsigned LENW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [DIVW-1:0]     div_val,
    input  logic [DSF_NCH-1:0]  chan_mask,
    input  logic                alt_mode,
    input  logic [DSF_DW-1:0]   offset,
    input  logic [LENW-1:0]     block_len,
    input  logic                s_valid,
    input  logic [DSF_DW-1:0]   s_data,
    output logic                s_ready,
    output logic [DSF_DW-1:0]   code0,
    output logic [DSF_DW-1:0]   code1,
    output logic                blk_done,
    output logic                starved
);
    logic                      en_q;
    logic                      start;
    logic                      tick;
    logic                      accept;
    code_t                     adj;
    lane_cmd_t [DSF_NCH-1:0]   cmd;
    code_t     [DSF_NCH-1:0]   codes;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= enable;
    end

    assign start   = enable && !en_q;
    assign s_ready = tick;
    assign accept  = s_valid && tick;
    assign adj     = sat_add(s_data, offset);

    dsf_tick_gen #(.DIVW(DIVW)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (enable),
        .div  (div_val),
        .tick (tick)
    );

    dsf_fanout u_fan (
        .clk    (clk),
        .rst    (rst),
        .en     (enable),
        .accept (accept),
        .mode   (fan_mode_t'(alt_mode)),
        .mask   (chan_mask),
        .val    (adj),
        .cmd    (cmd)
    );

    for (genvar c = 0; c < DSF_NCH; c++) begin : g_lane
        dsf_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .start (start),
            .cmd   (cmd[c]),
            .code  (codes[c])
        );
    end

    assign code0 = codes[0];
    assign code1 = codes[1];

    dsf_event_gen #(.LENW(LENW)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .en       (enable),
        .tick     (tick),
        .s_valid  (s_valid),
        .accept   (accept),
        .blk_len  (block_len),
        .blk_done (blk_done),
        .starved  (starved)
    );
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
    parameter int unsigned DIVW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            enable,
    input logic [DIVW-1:0] div_val,
    input logic [1:0]      chan_mask,
    input logic            alt_mode,
    input logic            s_valid,
    input logic            s_ready,
    input logic [7:0]      code0,
    input logic [7:0]      code1,
    input logic            blk_done,
    input logic            starved
);
    logic prev_en;

    always_ff @(posedge clk) begin
        if (rst)
            prev_en <= 1'b0;
        else
            prev_en <= enable;
    end

    p_ready_gated_r2: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !s_ready);

    p_ready_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (s_ready && div_val != '0 && $stable(div_val)) |=> !s_ready);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && prev_en && !(s_valid && s_ready)) |=> ($stable(code0) && $stable(code1)));

    p_simul_match_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && s_valid && s_ready && !alt_mode && chan_mask == 2'b11) |=> (code0 == code1));

    p_start_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (enable && !prev_en && !s_ready) |=> (code0 == 8'd0 && code1 == 8'd0));

    p_done_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> $past(s_valid && s_ready));

    p_starved_after_dry_r10: assert property (@(posedge clk) disable iff (rst)
        starved |-> $past(s_ready && !s_valid));
endmodule

bind dac_stream_fanout dsf_checker #(.DIVW(DIVW)) u_chk (.*);

// File: tb/dac_stream_fanout_bench.sv
module dac_stream_fanout_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [15:0] div_val;
    logic [1:0]  chan_mask;
    logic        alt_mode;
    logic [7:0]  offset;
    logic [15:0] block_len;
    logic        s_valid;
    logic [7:0]  s_data;
    logic        s_ready;
    logic [7:0]  code0;
    logic [7:0]  code1;
    logic        blk_done;
    logic        starved;

    int checks = 0;
    int errors = 0;
    int exp0 = 0;
    int exp1 = 0;

    always #4 clk = ~clk;

    dac_stream_fanout u_dac_stream_fanout (.*);

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic push(input int d);
        s_data  = 8'(d);
        s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        exp0 = 0;
        exp1 = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int offs [5] = '{-128, -1, 0, 7, 127};
        int gap;
        int seen;
        int turn;
        int v;

        rst = 1'b1; enable = 1'b0; div_val = 16'd1; chan_mask = 2'b11;
        alt_mode = 1'b0; offset = 8'd0; block_len = 16'd0;
        s_valid = 1'b0; s_data = 8'd0;
        repeat (4) @(negedge clk);
        chk("R1 code0 in reset", code0, 0);
        chk("R1 ready in reset", s_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code0", code0, 0);
        chk("R1 code1", code1, 0);
        chk("R1 s_ready", s_ready, 0);
        chk("R1 blk_done", blk_done, 0);
        chk("R1 starved", starved, 0);

        // R2: disabled gives no ticks; tick spacing follows div_val
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (s_ready) seen++;
        end
        chk("R2 no tick while disabled", seen, 0);
        for (int d = 0; d < 5; d++) begin
            div_val = 16'(d);
            restart();
            while (!s_ready) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                gap = 0;
                do begin
                    @(negedge clk);
                    gap++;
                end while (!s_ready);
                chk("R2 tick spacing", gap, d + 1);
            end
        end

        // R3, R4, R9 (block_len 0): full sweep of data at boundary offsets
        div_val = 16'd1; chan_mask = 2'b11; alt_mode = 1'b0; block_len = 16'd0;
        restart();
        foreach (offs[i]) begin
            offset = 8'(offs[i]);
            for (int d = 0; d < 256; d++) begin
                push(d);
                v = clamp(d + offs[i]);
                chk("R3 clamp code0", code0, v);
                chk("R4 copy code1", code1, v);
                chk("R9 len0 done", blk_done, 1);
            end
        end
        exp0 = code0; exp1 = code1;
        offset = 8'd0;

        // R4 single channel in copy mode
        chan_mask = 2'b01;
        push(33);
        chk("R4 mask01 code0", code0, 33);
        chk("R4 mask01 code1 held", code1, exp1);
        exp0 = 33;
        // R6 single channel in alternate mode
        chan_mask = 2'b10; alt_mode = 1'b1;
        for (int k = 0; k < 3; k++) begin
            push(40 + k);
            chk("R6 alt one ch code1", code1, 40 + k);
            chk("R6 alt one ch code0 held", code0, exp0);
        end
        exp1 = 42;

        // R11 mask 00 consumes without change
        chan_mask = 2'b00;
        push(99);
        chk("R11 code0 unchanged", code0, exp0);
        chk("R11 code1 unchanged", code1, exp1);

        // R7 hold over idle ticks
        repeat (10) @(negedge clk);
        chk("R7 hold code0", code0, exp0);
        chk("R7 hold code1", code1, exp1);

        // R8 start clears; R5 dealing order
        chan_mask = 2'b11; alt_mode = 1'b1;
        restart();
        chk("R8 start zero code0", code0, 0);
        chk("R8 start zero code1", code1, 0);
        turn = 0;
        for (int k = 1; k <= 6; k++) begin
            push(k * 10);
            if (turn == 0) exp0 = k * 10; else exp1 = k * 10;
            turn = 1 - turn;
            chk("R5 alt code0", code0, exp0);
            chk("R5 alt code1", code1, exp1);
        end
        push(77);                       // turn is 0 again: lands on code0
        chk("R5 alt wrap code0", code0, 77);
        restart();
        push(88);
        chk("R5 restart turn code0", code0, 88);
        chk("R5 restart turn code1", code1, 0);

        // R9 groups of three
        alt_mode = 1'b0; block_len = 16'd3;
        restart();
        for (int k = 0; k < 7; k++) begin
            push(k);
            chk("R9 group pulse", blk_done, (k % 3 == 2) ? 1 : 0);
            @(negedge clk);
            chk("R9 pulse one clock", blk_done, 0);
        end

        // R10 starved pulse
        restart();
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (starved) seen++;
        end
        chk("R10 no pulse before data", seen, 0);
        push(5);
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        chk("R10 dry pulse", starved, 1);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (starved) seen++;
        end
        chk("R10 single pulse", seen, 0);
        chk("R7 hold after dry code0", code0, 5);

        summary();
        $finish;
    end
endmodule